// File: doc/BRIEF.md
# Coincidence Trigger with Self-Blocking Veto and Downscaler

This block turns the two shaped pulses of a pair of photomultipliers on one scintillator into a trigger. A control level selects whether both pulses must overlap or whether either pulse is enough. The block registers the combined pulse and marks its leading edge as a one-clock raw trigger. That raw trigger becomes an accepted trigger only when triggering is enabled and no veto source is active.

The veto is the OR of three levels: the readout dead time, the busy level of the charge converter, and the accepted trigger itself. An accepted trigger therefore blocks any new trigger in the same cycle. A programmable divider makes a sparser copy of the accepted triggers, which forces periodic readout. Software clears the divider through a control level.

Top module: `coinc_trigger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `coinc`, `trig_raw`, `trig` and `trig_ds` are 0 and the divider count is zero.
- R2: `coinc` is a register. At each edge it loads `pmt_a & pmt_b` when `comb_or` is 0 (AND), and `pmt_a | pmt_b` when `comb_or` is 1 (OR).
- R3: `trig_raw` is high for exactly the one cycle in which `coinc` is 1 after having been 0 in the previous cycle.
- R4: `trig` is a one-cycle pulse. It is set in the cycle after `trig_raw` when, in the `trig_raw` cycle, `trig_en` was 1 and `veto` was 0.
- R5: With `trig_en` at 0, `trig` stays 0 whatever the pulses and veto sources do.
- R6: `veto` is combinationally `dead_time | conv_busy | trig`. A `trig_raw` that coincides with `veto` high yields no `trig`.
- R7: `veto_n` is always the complement of `veto`.
- R8: With `ds_factor` N of 2 or more, `trig_ds` pulses for one cycle in the cycle after every Nth `trig` pulse counted since reset, the last clear or the last `trig_ds`.
- R9: With `ds_factor` 0 or 1, every `trig` pulse is followed in the next cycle by a `trig_ds` pulse.
- R10: While `ds_clear` is 1, the divider count is held at zero and `trig_ds` is 0 in the following cycle. This holds even if a `trig` arrives. Counting restarts from zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pmt_a | input | 1 | Shaped pulse from the first photomultiplier |
| pmt_b | input | 1 | Shaped pulse from the second photomultiplier |
| dead_time | input | 1 | Readout total dead-time level |
| conv_busy | input | 1 | Charge converter busy level |
| comb_or | input | 1 | Combination select: 0 AND, 1 OR |
| trig_en | input | 1 | Trigger production enable |
| ds_clear | input | 1 | Divider count clear |
| ds_factor | input | 16 | Accepted triggers per downscaled trigger |
| coinc | output | 1 | Registered coincidence |
| trig_raw | output | 1 | Leading-edge pulse of the coincidence |
| trig | output | 1 | Accepted (vetoed) trigger pulse |
| trig_ds | output | 1 | Downscaled trigger pulse |
| veto | output | 1 | Veto level |
| veto_n | output | 1 | Complement of the veto level |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle between edges. They also assume that `ds_factor` is changed only when the bench wants its effect from the next accepted trigger on. The bench drives every input at the falling edge, so the pulses, veto levels and control bits are stable across each rising edge. Each phase holds the mode, enable and factor fixed and varies only the pulses, the veto sources and the clear.

// File: rtl/coinc_trigger_pkg.sv
// Shared definitions for the coincidence trigger.
// Assumes nothing beyond a synchronous design context.
package coinc_trigger_pkg;

    // Default width of the downscale factor and its counter
    localparam int unsigned DS_W_DEF = 16;

    // Combination mode of the two detector pulses
    typedef enum logic {
        COMB_AND = 1'b0,
        COMB_OR  = 1'b1
    } comb_mode_e;

endpackage

// File: rtl/ct_coincidence.sv
// Forms the registered coincidence of the two detector pulses and marks
// its leading edge as a one-cycle raw trigger.
// Assumes both pulses are synchronous to clk.
module ct_coincidence
    import coinc_trigger_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_a,
    input  logic       pulse_b,
    input  comb_mode_e mode,
    output logic       coinc_q,
    output logic       edge_pulse
);

    logic combined;
    logic coinc_prev;

    // Select AND or OR combination of the two pulses
    always_comb begin
        case (mode)
            COMB_OR: combined = pulse_a | pulse_b;
            default: combined = pulse_a & pulse_b;
        endcase
    end

    // Register the combination and keep its previous value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coinc_q    <= 1'b0;
            coinc_prev <= 1'b0;
        end else begin
            coinc_q    <= combined;
            coinc_prev <= coinc_q;
        end
    end

    // Leading edge of the registered coincidence
    assign edge_pulse = coinc_q & ~coinc_prev;

endmodule

// File: rtl/ct_veto_gate.sv
// Accepts a raw trigger when enabled and not vetoed. The veto is the OR of
// the external busy levels and the accepted trigger itself (self-blocking).
// Assumes the veto sources are synchronous levels.
module ct_veto_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic enable,
    input  logic dead_lvl,
    input  logic busy_lvl,
    output logic trig_q,
    output logic veto_lvl,
    output logic veto_lvl_n
);

    // Combine every veto source, including the trigger register
    always_comb begin
        veto_lvl   = dead_lvl | busy_lvl | trig_q;
        veto_lvl_n = ~veto_lvl;
    end

    // Register an accepted trigger as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= raw_in & enable & ~veto_lvl;
        end
    end

endmodule

// File: rtl/ct_downscaler.sv
// Emits one output pulse per FACTOR accepted triggers. A factor of 0 or 1
// passes each trigger through. A clear level holds the count at zero.
// Assumes the trigger input is a one-cycle pulse.
module ct_downscaler #(
    parameter int unsigned DS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_in,
    input  logic            clear,
    input  logic [DS_W-1:0] factor,
    output logic            ds_q
);

    localparam int unsigned CW = DS_W + 1;

    logic [DS_W-1:0] count;
    logic [CW-1:0]   count_next;
    logic            pass_all;
    logic            wrap;

    // Work out the next count value and whether this trigger completes a group
    always_comb begin
        count_next = {1'b0, count} + CW'(1);
        pass_all   = (factor <= DS_W'(1));
        wrap       = pass_all || (count_next >= {1'b0, factor});
    end

    // Count accepted triggers and emit the downscaled pulse
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            ds_q  <= 1'b0;
        end else if (trig_in) begin
            ds_q  <= wrap;
            count <= wrap ? '0 : count_next[DS_W-1:0];
        end else begin
            ds_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/coinc_trigger.sv
// Top of the coincidence trigger: coincidence and edge stage, veto gate,
// and downscaler in series.
// Assumes all inputs are synchronous to clk.
module coinc_trigger
    import coinc_trigger_pkg::*;
#(
    parameter int unsigned DS_W = DS_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pmt_a,
    input  logic            pmt_b,
    input  logic            dead_time,
    input  logic            conv_busy,
    input  logic            comb_or,
    input  logic            trig_en,
    input  logic            ds_clear,
    input  logic [DS_W-1:0] ds_factor,
    output logic            coinc,
    output logic            trig_raw,
    output logic            trig,
    output logic            trig_ds,
    output logic            veto,
    output logic            veto_n
);

    comb_mode_e mode;

    // Map the control level onto the mode type
    always_comb mode = comb_or ? COMB_OR : COMB_AND;

    ct_coincidence u_coinc (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_a    (pmt_a),
        .pulse_b    (pmt_b),
        .mode       (mode),
        .coinc_q    (coinc),
        .edge_pulse (trig_raw)
    );

    ct_veto_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (trig_raw),
        .enable     (trig_en),
        .dead_lvl   (dead_time),
        .busy_lvl   (conv_busy),
        .trig_q     (trig),
        .veto_lvl   (veto),
        .veto_lvl_n (veto_n)
    );

    ct_downscaler #(.DS_W(DS_W)) u_ds (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig),
        .clear   (ds_clear),
        .factor  (ds_factor),
        .ds_q    (trig_ds)
    );

endmodule

// File: rtl/coinc_trigger_chk.sv
// Property checker for the coincidence trigger, attached by bind.
// Assumes inputs are stable around each rising clock edge.
module coinc_trigger_chk #(
    parameter int unsigned DS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pmt_a,
    input logic            pmt_b,
    input logic            dead_time,
    input logic            conv_busy,
    input logic            comb_or,
    input logic            trig_en,
    input logic            ds_clear,
    input logic [DS_W-1:0] ds_factor,
    input logic            coinc,
    input logic            trig_raw,
    input logic            trig,
    input logic            trig_ds,
    input logic            veto,
    input logic            veto_n
);

    assert_coinc_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!comb_or && !(pmt_a && pmt_b)) |=> !coinc);

    assert_coinc_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_or && (pmt_a || pmt_b)) |=> coinc);

    assert_raw_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_raw |=> !trig_raw);

    assert_raw_needs_coinc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_raw |-> coinc);

    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_raw && trig_en && !veto) |=> trig);

    assert_trig_from_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(trig_raw));

    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> !trig);

    assert_vetoed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time || conv_busy) |=> !trig);

    assert_self_veto_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> veto);

    assert_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({veto, veto_n}) == 1);

    assert_ds_after_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ds |-> $past(trig));

    assert_pass_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && ds_factor <= DS_W'(1) && !ds_clear) |=> trig_ds);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ds_clear |=> !trig_ds);

endmodule

bind coinc_trigger coinc_trigger_chk #(.DS_W(DS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pmt_a     (pmt_a),
    .pmt_b     (pmt_b),
    .dead_time (dead_time),
    .conv_busy (conv_busy),
    .comb_or   (comb_or),
    .trig_en   (trig_en),
    .ds_clear  (ds_clear),
    .ds_factor (ds_factor),
    .coinc     (coinc),
    .trig_raw  (trig_raw),
    .trig      (trig),
    .trig_ds   (trig_ds),
    .veto      (veto),
    .veto_n    (veto_n)
);

// File: tb/coinc_trigger_tb.sv
module coinc_trigger_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pmt_a = 1'b0, pmt_b = 1'b0;
    logic        dead_time = 1'b0, conv_busy = 1'b0;
    logic        comb_or = 1'b0, trig_en = 1'b0, ds_clear = 1'b0;
    logic [15:0] ds_factor = 16'd0;
    logic        coinc, trig_raw, trig, trig_ds, veto, veto_n;

    int n_checks = 0;
    int n_fail   = 0;
    int ds_seen  = 0;
    int trig_seen = 0;
    bit done     = 0;

    // behavioural reference state
    int m_cq = 0, m_cprev = 0, m_trig = 0, m_cnt = 0, m_ds = 0;

    always #2.5 clk = ~clk;

    coinc_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .pmt_a(pmt_a), .pmt_b(pmt_b),
        .dead_time(dead_time), .conv_busy(conv_busy), .comb_or(comb_or),
        .trig_en(trig_en), .ds_clear(ds_clear), .ds_factor(ds_factor),
        .coinc(coinc), .trig_raw(trig_raw), .trig(trig), .trig_ds(trig_ds),
        .veto(veto), .veto_n(veto_n)
    );

    // reference model, advanced at each rising edge from the requirements
    always @(posedge clk) begin
        int comb, raw, vet, ntrig, nds, ncnt, f;
        if (!rst_n) begin
            m_cq = 0; m_cprev = 0; m_trig = 0; m_cnt = 0; m_ds = 0;
        end else begin
            comb  = comb_or ? (pmt_a | pmt_b) : (pmt_a & pmt_b);
            raw   = (m_cq == 1 && m_cprev == 0) ? 1 : 0;
            vet   = (dead_time || conv_busy || m_trig == 1) ? 1 : 0;
            ntrig = (raw == 1 && trig_en && vet == 0) ? 1 : 0;
            f     = ds_factor;
            nds   = 0;
            ncnt  = m_cnt;
            if (ds_clear) begin
                ncnt = 0;
            end else if (m_trig == 1) begin
                if (f <= 1 || m_cnt + 1 >= f) begin
                    nds = 1; ncnt = 0;
                end else begin
                    ncnt = m_cnt + 1;
                end
            end
            m_cprev = m_cq; m_cq = comb; m_trig = ntrig; m_cnt = ncnt; m_ds = nds;
        end
    end

    task automatic chk(input string req, input string sig, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
        end
    endtask

    // compare every output against the model, away from the rising edge
    task automatic compare_all(input string tag);
        int ev;
        ev = (dead_time || conv_busy || m_trig == 1) ? 1 : 0;
        chk({tag, " R2"}, "coinc", coinc, m_cq);
        chk({tag, " R3"}, "trig_raw", trig_raw, (m_cq == 1 && m_cprev == 0) ? 1 : 0);
        chk({tag, " R4"}, "trig", trig, m_trig);
        chk({tag, " R6"}, "veto", veto, ev);
        chk({tag, " R7"}, "veto_n", veto_n, 1 - ev);
        chk({tag, " R8"}, "trig_ds", trig_ds, m_ds);
        if (trig) trig_seen++;
        if (trig_ds) ds_seen++;
    endtask

    // run cycles with random pulses under fixed controls
    task automatic phase(input string tag, input int ncyc, input bit mode,
                         input bit en, input int veto_pct, input int fac,
                         input int clr_pct);
        comb_or = mode; trig_en = en; ds_factor = 16'(fac);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            compare_all(tag);
            pmt_a     = ($urandom % 100) < 45;
            pmt_b     = ($urandom % 100) < 45;
            dead_time = ($urandom % 100) < veto_pct;
            conv_busy = ($urandom % 100) < veto_pct;
            ds_clear  = ($urandom % 100) < clr_pct;
        end
    endtask

    // produce exactly one clean accepted trigger, then idle
    task automatic one_trigger;
        @(negedge clk); compare_all("dir"); pmt_a = 1; pmt_b = 1;
        @(negedge clk); compare_all("dir"); pmt_a = 0; pmt_b = 0;
        repeat (4) begin @(negedge clk); compare_all("dir"); end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "coinc", coinc, 0);
        chk("R1", "trig_raw", trig_raw, 0);
        chk("R1", "trig", trig, 0);
        chk("R1", "trig_ds", trig_ds, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "trig first cycle", trig, 0);
        chk("R1", "trig_ds first cycle", trig_ds, 0);

        phase("R2 and-mode", 1500, 1'b0, 1'b1, 0, 1, 0);
        phase("R2 or-mode", 1500, 1'b1, 1'b1, 0, 1, 0);
        phase("R5 disabled", 800, 1'b1, 1'b0, 0, 1, 0);
        phase("R6 veto", 1500, 1'b1, 1'b1, 20, 1, 0);
        phase("R8 factor3", 1500, 1'b1, 1'b1, 10, 3, 0);
        phase("R9 factor0", 800, 1'b0, 1'b1, 5, 0, 0);
        phase("R10 clear", 1500, 1'b1, 1'b1, 5, 4, 8);

        // R8 directed: factor 4, eight clean triggers give two downscaled ones
        dead_time = 0; conv_busy = 0; ds_clear = 0; pmt_a = 0; pmt_b = 0;
        trig_en = 1; ds_factor = 16'd4; comb_or = 0;
        @(negedge clk); compare_all("dir");
        ds_clear = 1; @(negedge clk); compare_all("dir"); ds_clear = 0;
        repeat (3) begin @(negedge clk); compare_all("dir"); end
        trig_seen = 0; ds_seen = 0;
        for (int k = 0; k < 8; k++) one_trigger();
        chk("R8", "trig count", trig_seen, 8);
        chk("R8", "ds count", ds_seen, 2);

        // R10 directed: three triggers, clear, three more -> no ds pulse
        trig_seen = 0; ds_seen = 0;
        for (int k = 0; k < 3; k++) one_trigger();
        ds_clear = 1; @(negedge clk); compare_all("dir"); ds_clear = 0;
        for (int k = 0; k < 3; k++) one_trigger();
        chk("R10", "ds count after clear", ds_seen, 0);

        // R5 directed: disabled, trigger attempt leaves trig low
        trig_en = 0; trig_seen = 0;
        one_trigger();
        chk("R5", "trig while disabled", trig_seen, 0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule